// File: doc/BRIEF.md
# Three-Channel Transfer Priority Arbiter with Completion Vector

This block decides which of three transfer channels owns the next transfer slot, and condenses the channels' completion events into a single prioritized interrupt code. Each channel raises a request line while it has a transfer waiting. When the slot is free, the arbiter picks one requester and holds a one-hot grant for it until the transfer engine reports the end of that transfer. A mode input selects, at run time, between a fixed order (channel 0 ahead of 1, 1 ahead of 2) and a rotating order where the channel just served drops to the back of the line.

In parallel, each channel can post a completion event. The block latches it as a flag and gates it with a per-channel enable and a global enable. The lowest-numbered gated flag is reported on an even-coded vector output, and an interrupt line is raised while any gated flag is pending. A read strobe on the vector acknowledges the reported source: its flag is cleared and the vector moves on to the next pending source.

No data moves through this block. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure: a request waits simply by staying high, and the grant stays up until the transfer-end pulse arrives.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the grant is all zeros, the interrupt line is low and the vector reads 0.
- R2: The grant is zero or one-hot. A grant appears in the clock cycle after the arbiter was idle and saw at least one request, and it always goes to a channel that was requesting in that idle cycle.
- R3: With the rotate mode input at 0, an idle arbiter grants the lowest-numbered requesting channel (channel 0 highest, channel 2 lowest).
- R4: With the rotate mode input at 1, the search starts at the channel after the one granted most recently (modulo 3), so that channel becomes lowest priority. The most recent grant is tracked in both modes. After reset, channel 2 counts as the most recent, so channel 0 leads the first rotating search.
- R5: Once given, a grant stays unchanged until the transfer-end input is high in a cycle with the grant held. Request changes during that time do not affect it. A transfer-end pulse while idle has no effect.
- R6: In the cycle after a transfer-end is accepted, the grant is zero. Arbitration resumes from that idle cycle.
- R7: A completion pulse for a channel sets that channel's flag from the next cycle. The flag stays set until it is acknowledged through a vector read. When a set and an acknowledge hit the same flag in the same cycle, the flag stays set.
- R8: A flag is pending only while its channel enable and the global enable are both high. The interrupt line is high exactly when some flag is pending.
- R9: The vector reads 0x02, 0x04 or 0x06 when channel 0, 1 or 2 (respectively) is the lowest-numbered pending channel, and 0x00 when none is pending. Only bits 3..1 can be non-zero.
- R10: A read strobe clears, at the clock edge, only the flag of the channel the vector reports in that cycle. A read while the vector is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 3 | Per-channel pending-transfer request |
| rr_mode_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| xfer_done_i | input | 1 | Pulse: the granted transfer has finished |
| cmpl_set_i | input | 3 | Per-channel completion pulse, sets the flag |
| ch_ie_i | input | 3 | Per-channel interrupt enable |
| gie_i | input | 1 | Global interrupt enable |
| vec_rd_i | input | 1 | Vector read strobe, acknowledges the reported source |
| grant_o | output | 3 | One-hot grant for the current transfer slot |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 16 | Prioritized interrupt vector |

## Verification
In fixed mode, all three channels request together and then drop out one at a time. The grant must follow the channel index, whatever was served before. The same full request pattern in rotating mode must give a 0,1,2 cycle of grants, which tells the rotating order apart from the fixed one. Requests that drop or change while a grant is held, and transfer-end pulses sent while idle, show that a grant is neither dropped nor replaced before the end of its transfer. Several flags are then posted together under different enable masks and read one after another. This exposes wrong vector order, clearing of the wrong source, and a lost flag when a set and a read coincide. A long pseudo-random mix that toggles the mode bit at run time covers the interplay of all these cases.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    SLOT_FREE = 1'b0,
    SLOT_HELD = 1'b1
  } slot_state_e;

  function automatic int unsigned vec_code(input int unsigned idx);
    return (idx + 1) * 2;
  endfunction
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NCH = 3,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req_i,
  input  logic           rotate_i,
  input  logic [IW-1:0]  last_i,
  output logic [NCH-1:0] pick_o,
  output logic [IW-1:0]  pick_idx_o,
  output logic           any_o
);
  int unsigned base;

  always_comb begin
    if (rotate_i) base = (int'(last_i) + 1) % NCH;
    else          base = 0;
  end

  always_comb begin
    pick_o     = '0;
    pick_idx_o = '0;
    any_o      = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      if (!any_o && req_i[(base + k) % NCH]) begin
        pick_o[(base + k) % NCH] = 1'b1;
        pick_idx_o               = IW'((base + k) % NCH);
        any_o                    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb_slot.sv
module dma_arb_slot
  import dma_arb_pkg::*;
#(
  parameter int NCH = 3,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pick_i,
  input  logic [IW-1:0]  pick_idx_i,
  input  logic           any_i,
  input  logic           done_i,
  output logic [NCH-1:0] grant_o,
  output logic [IW-1:0]  last_o
);
  slot_state_e     state_q;
  logic [NCH-1:0]  grant_q;
  logic [IW-1:0]   last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SLOT_FREE;
      grant_q <= '0;
      last_q  <= IW'(NCH - 1);
    end else begin
      case (state_q)
        SLOT_FREE: begin
          if (any_i) begin
            state_q <= SLOT_HELD;
            grant_q <= pick_i;
            last_q  <= pick_idx_i;
          end
        end
        SLOT_HELD: begin
          if (done_i) begin
            state_q <= SLOT_FREE;
            grant_q <= '0;
          end
        end
        default: begin
          state_q <= SLOT_FREE;
          grant_q <= '0;
        end
      endcase
    end
  end

  assign grant_o = grant_q;
  assign last_o  = last_q;
endmodule

// File: rtl/dma_arb_irq.sv
module dma_arb_irq
  import dma_arb_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   set_i,
  input  logic [NCH-1:0]   ie_i,
  input  logic             gie_i,
  input  logic             rd_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] top;

  assign pend  = flag_q & ie_i & {NCH{gie_i}};
  assign irq_o = |pend;

  always_comb begin
    top   = '0;
    vec_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        top      = '0;
        top[i]   = 1'b1;
        vec_o    = VEC_W'(vec_code(i));
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                flag_q[g] <= 1'b0;
      else if (set_i[g])         flag_q[g] <= 1'b1;
      else if (rd_i && top[g])   flag_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH   = 3,
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req_i,
  input  logic             rr_mode_i,
  input  logic             xfer_done_i,
  input  logic [NCH-1:0]   cmpl_set_i,
  input  logic [NCH-1:0]   ch_ie_i,
  input  logic             gie_i,
  input  logic             vec_rd_i,
  output logic [NCH-1:0]   grant_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] pick;
  logic [IW-1:0]  pick_idx;
  logic [IW-1:0]  last;
  logic           any;

  dma_arb_pick #(.NCH(NCH)) u_pick (
    .req_i      (req_i),
    .rotate_i   (rr_mode_i),
    .last_i     (last),
    .pick_o     (pick),
    .pick_idx_o (pick_idx),
    .any_o      (any)
  );

  dma_arb_slot #(.NCH(NCH)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_i     (pick),
    .pick_idx_i (pick_idx),
    .any_i      (any),
    .done_i     (xfer_done_i),
    .grant_o    (grant_o),
    .last_o     (last)
  );

  dma_arb_irq #(.NCH(NCH), .VEC_W(VEC_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (cmpl_set_i),
    .ie_i  (ch_ie_i),
    .gie_i (gie_i),
    .rd_i  (vec_rd_i),
    .irq_o (irq_o),
    .vec_o (vec_o)
  );
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
  parameter int NCH   = 3,
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   req_i,
  input logic             rr_mode_i,
  input logic             xfer_done_i,
  input logic             gie_i,
  input logic [NCH-1:0]   grant_o,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_grant_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && $past(grant_o) == '0) |-> ((grant_o & $past(req_i)) != '0));

  assert_fixed_ch0_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rr_mode_i && grant_o == '0 && req_i[0]) |=> grant_o[0]);

  assert_grant_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && !xfer_done_i) |=> (grant_o == $past(grant_o)));

  assert_gap_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && xfer_done_i) |=> (grant_o == '0));

  assert_no_irq_without_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> !irq_o);

  assert_vec_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o[0] == 1'b0) && ((vec_o >> 4) == '0));

  assert_vec_matches_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (vec_o != '0));
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NCH(NCH), .VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .rr_mode_i   (rr_mode_i),
  .xfer_done_i (xfer_done_i),
  .gie_i       (gie_i),
  .grant_o     (grant_o),
  .irq_o       (irq_o),
  .vec_o       (vec_o)
);

// File: tb/dma_prio_arb_bench.sv
`timescale 1ns/1ps
module dma_prio_arb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req = '0;
  logic        rr = 1'b0;
  logic        done = 1'b0;
  logic [2:0]  cset = '0;
  logic [2:0]  ie = '0;
  logic        gie = 1'b0;
  logic        vrd = 1'b0;
  logic [2:0]  grant;
  logic        irq;
  logic [15:0] vec;

  int n_vec = 0;
  int n_bad = 0;
  string tag = "R1";

  int m_gnt;
  int m_last;
  logic [2:0] m_flag;
  logic [31:0] lf = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  dma_prio_arb u_dma_prio_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rr_mode_i(rr),
    .xfer_done_i(done), .cmpl_set_i(cset), .ch_ie_i(ie), .gie_i(gie),
    .vec_rd_i(vrd), .grant_o(grant), .irq_o(irq), .vec_o(vec)
  );

  function automatic int top_pend();
    for (int i = 0; i < 3; i++)
      if (m_flag[i] && ie[i] && gie) return i;
    return -1;
  endfunction

  task automatic model_edge();
    int p;
    int c;
    int idx;
    if (!rst_n) begin
      m_gnt = -1; m_last = 2; m_flag = '0;
      return;
    end
    p = top_pend();
    if (m_gnt >= 0) begin
      if (done) m_gnt = -1;
    end else if (req != 3'b000) begin
      c = -1;
      for (int k = 0; k < 3; k++) begin
        idx = rr ? (m_last + 1 + k) % 3 : k;
        if (c < 0 && req[idx]) c = idx;
      end
      m_gnt = c; m_last = c;
    end
    if (vrd && p >= 0) m_flag[p] = 1'b0;
    m_flag = m_flag | cset;
  endtask

  task automatic compare();
    logic [2:0]  eg;
    logic        ei;
    logic [15:0] ev;
    int p;
    p  = top_pend();
    eg = (m_gnt < 0) ? 3'b000 : 3'(1 << m_gnt);
    ei = (p >= 0);
    ev = (p >= 0) ? 16'((p + 1) * 2) : 16'h0;
    n_vec++;
    if (grant !== eg || irq !== ei || vec !== ev) begin
      n_bad++;
      $display("FAIL %s t=%0t grant=%b/%b irq=%b/%b vec=%h/%h (actual/expected)",
               tag, $time, grant, eg, irq, ei, vec, ev);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    done = 1'b0; cset = '0; vrd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired in phase %s", tag);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_gnt = -1; m_last = 2; m_flag = '0;
    // R1: reset state, held and just after release
    tag = "R1";
    req = 3'b111; cset = 3'b111; ie = 3'b111; gie = 1'b1;
    repeat (3) step();
    req = '0; cset = '0;
    rst_n = 1'b1;
    step();

    // R3: fixed order, channels drop out one by one
    tag = "R3";
    rr = 1'b0; req = 3'b111;
    for (int n = 0; n < 6; n++) begin done = n[0]; step(); end
    req = 3'b110;
    for (int n = 0; n < 4; n++) begin done = n[0]; step(); end
    req = 3'b100;
    for (int n = 0; n < 4; n++) begin done = n[0]; step(); end
    req = 3'b101;
    for (int n = 0; n < 4; n++) begin done = n[0]; step(); end
    quiet(); req = '0; step();

    // R4: rotating order with all requesting, then partial sets
    tag = "R4";
    rr = 1'b1; req = 3'b111;
    for (int n = 0; n < 14; n++) begin done = n[0]; step(); end
    req = 3'b011;
    for (int n = 0; n < 8; n++) begin done = n[0]; step(); end
    req = 3'b101;
    for (int n = 0; n < 8; n++) begin done = n[0]; step(); end
    quiet(); req = '0; step();

    // R5: hold through request changes; done while idle ignored
    tag = "R5";
    rr = 1'b0;
    done = 1'b1; step(); step();
    done = 1'b0; req = 3'b100; step();
    req = 3'b001; step();
    req = 3'b000; step();
    req = 3'b011; rr = 1'b1; step(); step();
    done = 1'b1; step();

    // R6: one idle cycle after each accepted done
    tag = "R6";
    req = 3'b111;
    for (int n = 0; n < 10; n++) begin done = 1'b1; step(); end
    quiet(); req = '0; step();

    // R7 R8: flag latching under enable masks
    tag = "R7 R8";
    ie = 3'b000; gie = 1'b1;
    cset = 3'b110; step();
    cset = '0; step();
    ie = 3'b100; step();
    ie = 3'b010; step();
    gie = 1'b0; ie = 3'b111; step();
    gie = 1'b1; step();

    // R9: vector values and ordering
    tag = "R9";
    cset = 3'b001; step();
    cset = '0; step();
    ie = 3'b110; step();
    ie = 3'b100; step();
    ie = 3'b111; step();

    // R10: reads acknowledge in order, collisions keep the flag
    tag = "R10";
    vrd = 1'b1; step();
    vrd = 1'b1; cset = 3'b010; step();
    cset = '0; step();
    step();
    step();
    vrd = 1'b1; step();
    ie = 3'b011; cset = 3'b100; vrd = 1'b1; step();
    vrd = 1'b0; cset = '0; step();
    ie = 3'b111; step();
    vrd = 1'b1; step(); step();
    vrd = 1'b0; step();

    // R2: pseudo-random mix, mode toggled at run time
    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      lf   = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      req  = lf[2:0];
      done = lf[4] & lf[3];
      cset = lf[7:5] & {3{lf[8] & lf[9]}};
      ie   = (lf[12:10] | 3'b001);
      gie  = lf[13] | lf[14];
      vrd  = lf[15] & lf[16];
      if (lf[20:17] == 4'h0) rr = ~rr;
      step();
    end
    quiet(); req = '0; step();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule